// File: doc/BRIEF.md
# Hot-Swap Fault Supervisor

This block is the digital supervisor for a high-side hot-swap switch. It receives the results of the analog comparators as flags: supply above the upper and lower undervoltage thresholds, overpower, overcurrent, hard short, and load feedback above the power-good on and off levels. From these flags and an active-high enable it computes the gate-enable command for the external pass transistor. It also drives a latched active-low fault line, a pair of power-good outputs and two cause flags that report which delay expired.

Counters replace the capacitor ramps that time fault delays. The overpower and overcurrent conditions each have their own counter, and each counter clears as soon as its condition goes away. A hard short trips with no delay. A tripped fault stays latched until enable drops or power is removed. Power-good has a programmable qualification interval, nominally 500 ms of clock cycles, in both directions.

Every asynchronous input passes through a two-flop synchronizer. All latencies below count clock edges from the edge that first samples the changed input.

Top module: `hotswap_supervisor`

## Requirements
- R1: While the synchronized enable is low, `gate_o` is 0 whatever the other inputs are. A raised enable reaches `gate_o` two edges after it is first sampled.
- R2: The supply-OK state is set when the upper-threshold flag is high and cleared when the lower-threshold flag is low. `gate_o` is enable AND supply-OK AND not faulted. Losing only the upper flag keeps the gate on; losing the lower flag turns it off on the third edge.
- R3: The overpower counter advances on each cycle the synchronized overpower flag is high. It clears on any cycle the flag is low. The counter trips after `op_limit_i` consecutive high cycles, so fewer consecutive cycles with gaps never trip.
- R4: The overcurrent counter works the same way against `oc_limit_i` and runs independently of the overpower counter. When both run, the one that reaches its limit first trips the fault.
- R5: A trip drives `fault_no` low and `gate_o` low on the same edge. A hard short trips on the third edge after it is sampled, with no programmable delay. A limit of N trips on edge N+2. A limit of 0 acts as 1.
- R6: A latched fault holds while enable stays high. When the synchronized enable is low, the fault, both counters and both cause flags clear. After enable returns, the gate restarts normally.
- R7: While a fault is latched, the cause flags are {op_flag_o, oc_flag_o} = 10 for overpower, 01 for overcurrent and 00 for a short. Both flags are 0 while no fault is latched.
- R8: With `cur_only_i` = 1, the overpower flag never trips a fault and `op_flag_o` stays 0.
- R9: `pg_o` rises after the on-level flag has been high for `pg_limit_i` consecutive cycles. It falls after the off-level flag has been low for `pg_limit_i` consecutive cycles. `pg_no` is always the complement of `pg_o`.
- R10: A latched fault forces `pg_o` to 0 and holds the power-good timer at zero. Qualification restarts only after the fault clears.
- R11: After reset (power removal), `gate_o`=0, `fault_no`=1, `pg_o`=0, `pg_no`=1 and both cause flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power removal) |
| en_i | input | 1 | Enable, active high, asynchronous |
| uv_hi_i | input | 1 | Supply above upper undervoltage threshold |
| uv_lo_i | input | 1 | Supply above lower undervoltage threshold |
| op_det_i | input | 1 | Overpower condition detected |
| oc_det_i | input | 1 | Overcurrent condition detected |
| short_det_i | input | 1 | Hard short detected |
| fb_on_i | input | 1 | Load feedback above power-good on level |
| fb_off_i | input | 1 | Load feedback above power-good off level |
| cur_only_i | input | 1 | 1 disables overpower detection |
| op_limit_i | input | DLY_W | Overpower delay in cycles |
| oc_limit_i | input | DLY_W | Overcurrent delay in cycles |
| pg_limit_i | input | PG_W | Power-good qualification interval in cycles |
| gate_o | output | 1 | Gate-enable command |
| fault_no | output | 1 | Latched fault, active low |
| pg_o | output | 1 | Power good, active high |
| pg_no | output | 1 | Power good, active low |
| op_flag_o | output | 1 | Overpower delay caused the fault |
| oc_flag_o | output | 1 | Overcurrent delay caused the fault |

## Verification
A delay counter that fails to clear between bursts shows up as a `fault_no` fall on the edge where the second burst completes the total. The checks therefore place gapped bursts whose lengths add up past the limit. A fault latch that drops without an enable drop, or cause flags written with the wrong channel, show at the ports on the very next edge, and assertions watch for them continuously. A power-good timer left running through a fault would raise `pg_o` early after the fault clears. The restart edge is therefore checked exactly, one cycle before and on the expected cycle.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int N_DLY = 2;
  typedef enum int {CH_OP = 0, CH_OC = 1} dly_ch_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/hs_timer.sv
// Consecutive-cycle qualifier: hit_o on the lim-th consecutive cond cycle.
module hs_timer #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         cond_i,
  input  logic [W-1:0] lim_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q, lim_eff;
  assign lim_eff = (lim_i == '0) ? W'(1) : lim_i;
  assign hit_o   = cond_i && !clr_i && (cnt_q == lim_eff - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i || !cond_i || hit_o)  cnt_q <= '0;
    else                                 cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/hotswap_supervisor.sv
module hotswap_supervisor
  import hs_pkg::*;
#(
  parameter int DLY_W = 24,
  parameter int PG_W  = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             uv_hi_i,
  input  logic             uv_lo_i,
  input  logic             op_det_i,
  input  logic             oc_det_i,
  input  logic             short_det_i,
  input  logic             fb_on_i,
  input  logic             fb_off_i,
  input  logic             cur_only_i,
  input  logic [DLY_W-1:0] op_limit_i,
  input  logic [DLY_W-1:0] oc_limit_i,
  input  logic [PG_W-1:0]  pg_limit_i,
  output logic             gate_o,
  output logic             fault_no,
  output logic             pg_o,
  output logic             pg_no,
  output logic             op_flag_o,
  output logic             oc_flag_o
);
  localparam int N_SYNC = 8;

  logic [N_SYNC-1:0] raw, syn;
  logic en_s, hi_s, lo_s, op_s, oc_s, sc_s, fon_s, foff_s;

  assign raw = {en_i, uv_hi_i, uv_lo_i, op_det_i, oc_det_i, short_det_i, fb_on_i, fb_off_i};
  hs_sync #(.W(N_SYNC)) u_sync (.clk_i, .rst_ni, .d_i(raw), .q_o(syn));
  assign {en_s, hi_s, lo_s, op_s, oc_s, sc_s, fon_s, foff_s} = syn;

  // Supply hysteresis
  logic sup_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sup_ok_q <= 1'b0;
    else if (hi_s)  sup_ok_q <= 1'b1;
    else if (!lo_s) sup_ok_q <= 1'b0;
  end

  logic fault_q, fault_set, dly_clr;
  logic [N_DLY-1:0] dly_cond, dly_hit;
  logic [DLY_W-1:0] dly_lim [N_DLY];

  assign dly_clr         = !en_s || fault_q;
  assign dly_cond[CH_OP] = op_s && !cur_only_i;
  assign dly_cond[CH_OC] = oc_s;
  assign dly_lim[CH_OP]  = op_limit_i;
  assign dly_lim[CH_OC]  = oc_limit_i;

  for (genvar ch = 0; ch < N_DLY; ch++) begin : g_dly
    hs_timer #(.W(DLY_W)) u_tmr (
      .clk_i, .rst_ni,
      .clr_i (dly_clr),
      .cond_i(dly_cond[ch]),
      .lim_i (dly_lim[ch]),
      .hit_o (dly_hit[ch])
    );
  end

  assign fault_set = en_s && !fault_q && ((|dly_hit) || sc_s);

  logic op_flag_q, oc_flag_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q   <= 1'b0;
      op_flag_q <= 1'b0;
      oc_flag_q <= 1'b0;
    end else if (!en_s) begin
      fault_q   <= 1'b0;
      op_flag_q <= 1'b0;
      oc_flag_q <= 1'b0;
    end else if (fault_set) begin
      fault_q   <= 1'b1;
      op_flag_q <= dly_hit[CH_OP];
      oc_flag_q <= dly_hit[CH_OC];
    end
  end

  // Power-good: one timer qualifies whichever transition is pending
  logic pg_q, pg_clr, pg_cond, pg_hit;
  assign pg_clr  = fault_q || fault_set;
  assign pg_cond = pg_q ? !foff_s : fon_s;

  hs_timer #(.W(PG_W)) u_pg_tmr (
    .clk_i, .rst_ni,
    .clr_i (pg_clr),
    .cond_i(pg_cond),
    .lim_i (pg_limit_i),
    .hit_o (pg_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pg_q <= 1'b0;
    else if (pg_clr) pg_q <= 1'b0;
    else if (pg_hit) pg_q <= !pg_q;
  end

  assign gate_o    = en_s && sup_ok_q && !fault_q;
  assign fault_no  = !fault_q;
  assign pg_o      = pg_q;
  assign pg_no     = !pg_q;
  assign op_flag_o = op_flag_q;
  assign oc_flag_o = oc_flag_q;
endmodule

// File: rtl/hs_sva_checker.sv
module hs_sva_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic short_det_i,
  input logic cur_only_i,
  input logic gate_o,
  input logic fault_no,
  input logic pg_o,
  input logic op_flag_o,
  input logic oc_flag_o
);
  logic [2:0] age_q;
  logic       warm;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= '0;
    else if (age_q != 3'd7)   age_q <= age_q + 3'd1;
  end
  assign warm = (age_q >= 3'd5);

  AST_GATE_EN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm && !$past(en_i, 2) |-> !gate_o); // R1
  AST_SHORT_NO_DLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm && $past(short_det_i, 3) && $past(en_i, 3) |-> !fault_no); // R5
  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm && !fault_no && $past(en_i, 2) |=> !fault_no); // R6
  AST_FLAG_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_no |-> !op_flag_o && !oc_flag_o); // R7
  AST_CUR_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm && cur_only_i && $past(cur_only_i) |-> !$rose(op_flag_o)); // R8
  AST_PG_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_no |-> !pg_o); // R10
endmodule

bind hotswap_supervisor hs_sva_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .short_det_i(short_det_i),
  .cur_only_i (cur_only_i),
  .gate_o     (gate_o),
  .fault_no   (fault_no),
  .pg_o       (pg_o),
  .op_flag_o  (op_flag_o),
  .oc_flag_o  (oc_flag_o)
);

// File: tb/tb_hotswap_supervisor.sv
module tb_hotswap_supervisor;
  logic clk_i = 1'b0;
  logic rst_ni;
  logic en_i, uv_hi_i, uv_lo_i, op_det_i, oc_det_i, short_det_i, fb_on_i, fb_off_i, cur_only_i;
  logic [23:0] op_limit_i, oc_limit_i;
  logic [24:0] pg_limit_i;
  logic gate_o, fault_no, pg_o, pg_no, op_flag_o, oc_flag_o;

  always #10 clk_i = ~clk_i;

  hotswap_supervisor dut (.*);

  typedef struct {
    int         cyc;
    logic [4:0] v;   // {gate, fault_n, pg, op_flag, oc_flag}
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic push(int d, logic [4:0] v, string tag);
    exp_t x;
    x.cyc = cyc + d;
    x.v   = v;
    x.tag = tag;
    q.push_back(x);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // Monitor
  initial forever begin
    logic [4:0] act;
    @(negedge clk_i);
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      e = q.pop_front();
      act = {gate_o, fault_no, pg_o, op_flag_o, oc_flag_o};
      checks++;
      if (act !== e.v || pg_no !== ~pg_o) begin
        errors++;
        $display("FAIL %s cyc=%0d act=%b exp=%b pg_no=%b", e.tag, cyc, act, e.v, pg_no);
      end
    end
  end

  // Driver
  initial begin
    rst_ni = 0; en_i = 0; uv_hi_i = 0; uv_lo_i = 0; op_det_i = 0; oc_det_i = 0;
    short_det_i = 0; fb_on_i = 0; fb_off_i = 0; cur_only_i = 0;
    op_limit_i = 24'd4; oc_limit_i = 24'd6; pg_limit_i = 25'd5;
    tick(3);
    rst_ni = 1;
    push(1, 5'b01000, "R11 reset state");
    tick(3);

    uv_hi_i = 1; uv_lo_i = 1;
    push(5, 5'b01000, "R1 enable low keeps gate off");
    tick(6);
    en_i = 1;
    push(1, 5'b01000, "R2 gate not yet on");
    push(2, 5'b11000, "R2 gate on");
    tick(4);

    uv_hi_i = 0;
    push(5, 5'b11000, "R2 hysteresis hold");
    tick(6);
    uv_lo_i = 0;
    push(2, 5'b11000, "R2 before lower drop");
    push(3, 5'b01000, "R2 below lower");
    tick(4);
    uv_hi_i = 1; uv_lo_i = 1;
    push(3, 5'b11000, "R2 restart");
    tick(5);

    op_det_i = 1;
    push(12, 5'b11000, "R3 gapped bursts cleared");
    tick(3); op_det_i = 0;
    tick(1); op_det_i = 1;
    tick(3); op_det_i = 0;
    tick(10);

    op_det_i = 1;
    push(5, 5'b11000, "R3 before limit");
    push(6, 5'b00010, "R5 R7 overpower trip");
    tick(8);
    op_det_i = 0;
    push(8, 5'b00010, "R6 fault latched");
    tick(10);

    en_i = 0;
    push(2, 5'b00010, "R6 fault before clear");
    push(3, 5'b01000, "R6 cleared by enable");
    tick(5);
    en_i = 1;
    push(2, 5'b11000, "R6 resume");
    tick(4);

    op_limit_i = 24'd10;
    op_det_i = 1; oc_det_i = 1;
    push(7, 5'b11000, "R4 both running");
    push(8, 5'b00001, "R4 R7 overcurrent first");
    tick(10);
    op_det_i = 0; oc_det_i = 0; op_limit_i = 24'd4;
    en_i = 0;
    push(3, 5'b01000, "R6 clear after overcurrent");
    tick(5);
    en_i = 1;
    tick(4);

    short_det_i = 1;
    push(2, 5'b11000, "R5 short before trip");
    push(3, 5'b00000, "R5 R7 short no delay");
    tick(4);
    short_det_i = 0; en_i = 0;
    tick(5);
    en_i = 1;
    tick(4);

    cur_only_i = 1; op_det_i = 1;
    push(20, 5'b11000, "R8 current-only ignores overpower");
    tick(22);
    op_det_i = 0; cur_only_i = 0;
    tick(3);

    fb_on_i = 1; fb_off_i = 1;
    push(6, 5'b11000, "R9 pg pending");
    push(7, 5'b11100, "R9 pg on");
    tick(8);
    fb_on_i = 0;
    push(10, 5'b11100, "R9 pg hysteresis");
    tick(11);
    fb_off_i = 0;
    push(6, 5'b11100, "R9 release pending");
    push(7, 5'b11000, "R9 pg off");
    tick(8);
    fb_on_i = 1; fb_off_i = 1;
    push(7, 5'b11100, "R9 pg on again");
    tick(9);

    short_det_i = 1;
    push(3, 5'b00000, "R10 fault drops pg");
    tick(4);
    short_det_i = 0;
    push(8, 5'b00000, "R10 pg held off");
    tick(10);
    en_i = 0;
    push(3, 5'b01000, "R10 fault cleared");
    tick(4);
    en_i = 1;
    push(2, 5'b11000, "R10 gate back");
    push(3, 5'b11000, "R10 pg still qualifying");
    push(4, 5'b11100, "R10 pg restarts");
    tick(10);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog expired act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule